// File: doc/BRIEF.md
# Word-to-Byte Packing Data Buffer

This block sits between a 16-bit register data port and a byte-serial bus engine. It holds up to four bytes in one shared storage word. A register write queues two bytes for transmission, and a register read removes the two oldest received bytes. On the engine side, transmit bytes leave through a pop strobe and received bytes arrive through a push strobe.

A per-access byte-order input decides which half of the 16-bit word is the earlier byte on the wire. Transmit and receive keep their own byte counts. Only one direction is expected to be active at a time, so both share the storage without arbitration. Sticky status outputs report transmit ready, transmit underflow, receive ready, receive overrun and a read that found only a single byte.

Top module: `pkb_buffer`

## Requirements
- R1: After reset both byte counts are 0, every status flag is 0, `tx_valid` is 0, and `tx_byte` and `rd_data` read 0.
- R2: A write (`wr_en`) is accepted when the transmit count is at most 2 and then raises the count by 2. When 3 or 4 bytes are held, the write is ignored: the count and the queued bytes are unchanged.
- R3: With `big_endian`=1, `wr_data[15:8]` is sent before `wr_data[7:0]`. With `big_endian`=0, `wr_data[7:0]` is sent first.
- R4: Transmit bytes leave in first-in first-out order, including a write that lands behind one leftover byte. Each non-empty pop lowers the count by 1, and `tx_valid` is 1 exactly when the count is non-zero.
- R5: A pop with no byte held returns 0 on `tx_byte` and sets `tx_underflow`. An accepted write clears `tx_underflow`.
- R6: Every pop sets `tx_ready`. An accepted write that leaves more than 2 bytes held clears it.
- R7: A push with fewer than 4 bytes held stores the byte behind the held ones and raises the receive count by 1. A push into a full buffer sets `rx_overrun` and changes neither the count nor the data. Every push sets `rx_ready`.
- R8: `rd_data` shows the two oldest received bytes. With `big_endian`=1 the oldest is in `[15:8]`; with 0 it is in `[7:0]`. A byte position that is not held reads 0.
- R9: A read (`rd_en`) with 2 or more bytes held lowers the count by 2, moves the next pair into view, and clears `rx_single`. A read with exactly 1 byte held sets `rx_single` and empties the buffer. A read with nothing held changes neither count nor `rx_single`.
- R10: Every read clears `rx_overrun`. A read that leaves the receive buffer empty clears `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Byte order of the 16-bit data port |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 16 | Word written to the transmit side |
| rd_en | input | 1 | Data register read strobe (pops the shown pair) |
| rd_data | output | 16 | Oldest two received bytes, ordered by `big_endian` |
| tx_pop | input | 1 | Engine takes the presented transmit byte |
| tx_valid | output | 1 | At least one transmit byte is held |
| tx_byte | output | 8 | Oldest transmit byte, 0 when empty |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_count | output | 3 | Transmit bytes held |
| rx_count | output | 3 | Receive bytes held |
| tx_ready | output | 1 | Room for another word was signalled by a pop |
| tx_underflow | output | 1 | A pop found the transmit side empty |
| rx_ready | output | 1 | Received data is waiting |
| rx_overrun | output | 1 | A received byte was dropped because the buffer was full |
| rx_single | output | 1 | The last read found only one byte |

## Verification
Words are sent with both settings of the byte order, and the wire order of each pair shows whether the swap is applied on the correct side. A write arrives while one byte is still left over, which separates a true FIFO shift from a simple reload. A write is also made against a full buffer and the bytes popped afterwards show whether it was dropped. On receive, odd byte counts, full buffers and reads of an empty buffer distinguish the single-byte, overrun and no-op paths. Reading with each byte order shows that unheld positions are masked.

// File: rtl/pkb_pkg.sv
package pkb_pkg;
   // bytes moved by one access of the register data port
   localparam int unsigned PKB_WORD_BYTES = 2;

   typedef struct packed {
      logic ready;
      logic underflow;
   } pkb_tx_flags_t;

   typedef struct packed {
      logic ready;
      logic overrun;
      logic single;
   } pkb_rx_flags_t;
endpackage

// File: rtl/pkb_order.sv
module pkb_order #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                  swap,
   input  logic [2*BYTE_W-1:0]   din,
   output logic [2*BYTE_W-1:0]   dout
);
   localparam int unsigned PAIR_W = 2 * BYTE_W;

   logic [PAIR_W-1:0] swapped;
   assign swapped = {din[BYTE_W-1:0], din[PAIR_W-1:BYTE_W]};
   assign dout    = swap ? swapped : din;
endmodule

// File: rtl/pkb_tx_ctl.sv
module pkb_tx_ctl
   import pkb_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             pop,
   output logic [CNT_W-1:0] cnt,
   output logic             accept,
   output pkb_tx_flags_t    flags
);
   localparam logic [CNT_W-1:0] STEP      = CNT_W'(PKB_WORD_BYTES);
   localparam logic [CNT_W-1:0] WR_LIMIT  = CNT_W'(DEPTH - PKB_WORD_BYTES);
   localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, after_pop, cnt_d;
   logic             take;
   pkb_tx_flags_t    flags_q, flags_d;

   assign take      = pop && (cnt_q != '0);
   assign accept    = wr_en && (cnt_q <= WR_LIMIT);
   assign after_pop = take ? (cnt_q - ONE) : cnt_q;
   assign cnt_d     = accept ? (after_pop + STEP) : after_pop;

   always_comb begin
      flags_d = flags_q;
      if (pop)
         flags_d.ready = 1'b1;
      if (accept && (cnt_d > STEP))
         flags_d.ready = 1'b0;
      if (pop && (cnt_q == '0))
         flags_d.underflow = 1'b1;
      if (accept)
         flags_d.underflow = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         flags_q <= '0;
      end else begin
         cnt_q   <= cnt_d;
         flags_q <= flags_d;
      end
   end

   assign cnt   = cnt_q;
   assign flags = flags_q;

   a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
   a_r2_write_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pop && cnt_q <= WR_LIMIT) |=> (cnt_q == $past(cnt_q) + STEP));
   a_r2_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pop && cnt_q > WR_LIMIT) |=> $stable(cnt_q));
   a_r4_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !wr_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
   a_r5_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !wr_en && cnt_q == '0) |=> flags_q.underflow);
   a_r6_ready_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !wr_en) |=> flags_q.ready);
endmodule

// File: rtl/pkb_rx_ctl.sv
module pkb_rx_ctl
   import pkb_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic             push,
   output logic [CNT_W-1:0] cnt,
   output logic             shift_down,
   output logic             place,
   output logic [CNT_W-1:0] place_pos,
   output pkb_rx_flags_t    flags
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(PKB_WORD_BYTES);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, after_read, cnt_d;
   pkb_rx_flags_t    flags_q, flags_d;

   always_comb begin
      if (!rd_en || cnt_q == '0)
         after_read = cnt_q;
      else if (cnt_q == ONE)
         after_read = '0;
      else
         after_read = cnt_q - STEP;
   end

   assign shift_down = rd_en && (cnt_q > STEP);
   assign place      = push && (after_read < FULL);
   assign place_pos  = after_read;
   assign cnt_d      = place ? (after_read + ONE) : after_read;

   always_comb begin
      flags_d = flags_q;
      if (rd_en && cnt_q == ONE)
         flags_d.single = 1'b1;
      if (rd_en && cnt_q >= STEP)
         flags_d.single = 1'b0;
      if (rd_en)
         flags_d.overrun = 1'b0;
      if (push && !place)
         flags_d.overrun = 1'b1;
      if (rd_en && cnt_q != '0 && after_read == '0)
         flags_d.ready = 1'b0;
      if (push)
         flags_d.ready = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         flags_q <= '0;
      end else begin
         cnt_q   <= cnt_d;
         flags_q <= flags_d;
      end
   end

   assign cnt   = cnt_q;
   assign flags = flags_q;

   a_r7_push_step: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !rd_en && cnt_q < FULL) |=> (cnt_q == $past(cnt_q) + ONE));
   a_r7_overrun_full: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !rd_en && cnt_q == FULL) |=> (flags_q.overrun && cnt_q == FULL));
   a_r9_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !push && cnt_q == ONE) |=> (flags_q.single && cnt_q == '0));
   a_r10_read_clears_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !push) |=> !flags_q.overrun);
endmodule

// File: rtl/pkb_store.sv
module pkb_store #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned CNT_W  = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_pair,
   input  logic [2*BYTE_W-1:0]       pair,
   input  logic                      shift_down,
   input  logic                      place,
   input  logic [CNT_W-1:0]          place_pos,
   input  logic [BYTE_W-1:0]         place_byte,
   output logic [DEPTH*BYTE_W-1:0]   lanes
);
   logic [BYTE_W-1:0] cur         [DEPTH];
   logic [BYTE_W-1:0] after_load  [DEPTH];
   logic [BYTE_W-1:0] after_shift [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_lane
      logic [BYTE_W-1:0] q;

      assign cur[i]                        = q;
      assign lanes[i*BYTE_W +: BYTE_W]     = q;

      // a write moves every held byte up by one word
      if (i >= 2) begin : g_up
         assign after_load[i] = load_pair ? cur[i-2] : cur[i];
      end else begin : g_in
         assign after_load[i] = load_pair ? pair[i*BYTE_W +: BYTE_W] : cur[i];
      end

      // a read moves the remaining bytes down by one word
      if (i + 2 < DEPTH) begin : g_down
         assign after_shift[i] = shift_down ? after_load[i+2] : after_load[i];
      end else begin : g_top
         assign after_shift[i] = shift_down ? '0 : after_load[i];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (place && place_pos == CNT_W'(i))
            q <= place_byte;
         else
            q <= after_shift[i];
      end
   end
endmodule

// File: rtl/pkb_buffer.sv
module pkb_buffer
   import pkb_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned DEPTH  = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                big_endian,
   input  logic                                wr_en,
   input  logic [PKB_WORD_BYTES*BYTE_W-1:0]    wr_data,
   input  logic                                rd_en,
   output logic [PKB_WORD_BYTES*BYTE_W-1:0]    rd_data,
   input  logic                                tx_pop,
   output logic                                tx_valid,
   output logic [BYTE_W-1:0]                   tx_byte,
   input  logic                                rx_push,
   input  logic [BYTE_W-1:0]                   rx_byte,
   output logic [$clog2(DEPTH+1)-1:0]          tx_count,
   output logic [$clog2(DEPTH+1)-1:0]          rx_count,
   output logic                                tx_ready,
   output logic                                tx_underflow,
   output logic                                rx_ready,
   output logic                                rx_overrun,
   output logic                                rx_single
);
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
   localparam int unsigned WORD_W = PKB_WORD_BYTES * BYTE_W;

   if (DEPTH < PKB_WORD_BYTES || (DEPTH % PKB_WORD_BYTES) != 0) begin : g_bad_depth
      $error("pkb_buffer: DEPTH must be a non-zero multiple of the word size");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("pkb_buffer: BYTE_W must be at least 1");
   end

   logic [CNT_W-1:0]        tx_cnt, rx_cnt, place_pos;
   logic                    accept, shift_down, place;
   logic [WORD_W-1:0]       pair_in, held_pair;
   logic [DEPTH*BYTE_W-1:0] lanes;
   pkb_tx_flags_t           tx_flags;
   pkb_rx_flags_t           rx_flags;

   pkb_tx_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .pop    (tx_pop),
      .cnt    (tx_cnt),
      .accept (accept),
      .flags  (tx_flags)
   );

   pkb_rx_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_en),
      .push       (rx_push),
      .cnt        (rx_cnt),
      .shift_down (shift_down),
      .place      (place),
      .place_pos  (place_pos),
      .flags      (rx_flags)
   );

   // lane 1 of the incoming pair is the one sent first
   pkb_order #(.BYTE_W(BYTE_W)) u_wr_order (
      .swap (!big_endian),
      .din  (wr_data),
      .dout (pair_in)
   );

   pkb_store #(.BYTE_W(BYTE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_pair  (accept),
      .pair       (pair_in),
      .shift_down (shift_down),
      .place      (place),
      .place_pos  (place_pos),
      .place_byte (rx_byte),
      .lanes      (lanes)
   );

   // oldest transmit byte sits at lane count-1
   always_comb begin
      tx_byte = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (tx_cnt == CNT_W'(i + 1))
            tx_byte = lanes[i*BYTE_W +: BYTE_W];
      end
   end

   // receive lanes 0 and 1 hold the oldest pair; mask positions not held
   assign held_pair[BYTE_W-1:0]      = (rx_cnt >= CNT_W'(1)) ? lanes[BYTE_W-1:0] : '0;
   assign held_pair[WORD_W-1:BYTE_W] = (rx_cnt >= CNT_W'(2)) ? lanes[WORD_W-1:BYTE_W] : '0;

   pkb_order #(.BYTE_W(BYTE_W)) u_rd_order (
      .swap (big_endian),
      .din  (held_pair),
      .dout (rd_data)
   );

   assign tx_valid     = (tx_cnt != '0);
   assign tx_count     = tx_cnt;
   assign rx_count     = rx_cnt;
   assign tx_ready     = tx_flags.ready;
   assign tx_underflow = tx_flags.underflow;
   assign rx_ready     = rx_flags.ready;
   assign rx_overrun   = rx_flags.overrun;
   assign rx_single    = rx_flags.single;

   a_r4_valid_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop && !wr_en && tx_count == CNT_W'(1)) |=> !tx_valid);
   a_r5_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |-> (tx_byte == '0));
endmodule

// File: tb/pkb_buffer_bench.sv
module pkb_buffer_bench;
   localparam int NV = 39;
   localparam logic [2:0] OP_WR = 3'd0, OP_POP = 3'd1, OP_PUSH = 3'd2,
                          OP_RD = 3'd3, OP_TXC = 3'd4, OP_RXC = 3'd5;

   // {op, big_endian, data, expected, requirement number}
   localparam logic [39:0] VECS [0:NV-1] = '{
      {OP_WR,  1'b1, 16'hA1B2, 16'h0000, 4'd3},
      {OP_POP, 1'b0, 16'h0000, 16'h00A1, 4'd3},
      {OP_POP, 1'b0, 16'h0000, 16'h00B2, 4'd3},
      {OP_WR,  1'b0, 16'hC3D4, 16'h0000, 4'd3},
      {OP_POP, 1'b0, 16'h0000, 16'h00D4, 4'd3},
      {OP_POP, 1'b0, 16'h0000, 16'h00C3, 4'd3},
      {OP_WR,  1'b1, 16'h1122, 16'h0000, 4'd4},
      {OP_POP, 1'b0, 16'h0000, 16'h0011, 4'd4},
      {OP_WR,  1'b1, 16'h3344, 16'h0000, 4'd4},
      {OP_TXC, 1'b0, 16'h0000, 16'h0003, 4'd2},
      {OP_POP, 1'b0, 16'h0000, 16'h0022, 4'd4},
      {OP_POP, 1'b0, 16'h0000, 16'h0033, 4'd4},
      {OP_POP, 1'b0, 16'h0000, 16'h0044, 4'd4},
      {OP_TXC, 1'b0, 16'h0000, 16'h0000, 4'd4},
      {OP_WR,  1'b1, 16'h5566, 16'h0000, 4'd2},
      {OP_WR,  1'b1, 16'h7788, 16'h0000, 4'd2},
      {OP_TXC, 1'b0, 16'h0000, 16'h0004, 4'd2},
      {OP_WR,  1'b1, 16'h99AA, 16'h0000, 4'd2},
      {OP_TXC, 1'b0, 16'h0000, 16'h0004, 4'd2},
      {OP_POP, 1'b0, 16'h0000, 16'h0055, 4'd2},
      {OP_POP, 1'b0, 16'h0000, 16'h0066, 4'd2},
      {OP_POP, 1'b0, 16'h0000, 16'h0077, 4'd2},
      {OP_POP, 1'b0, 16'h0000, 16'h0088, 4'd2},
      {OP_POP, 1'b0, 16'h0000, 16'h0000, 4'd5},
      {OP_PUSH,1'b0, 16'h0001, 16'h0000, 4'd7},
      {OP_PUSH,1'b0, 16'h0002, 16'h0000, 4'd7},
      {OP_PUSH,1'b0, 16'h0003, 16'h0000, 4'd7},
      {OP_RXC, 1'b0, 16'h0000, 16'h0003, 4'd7},
      {OP_RD,  1'b1, 16'h0000, 16'h0102, 4'd8},
      {OP_RXC, 1'b0, 16'h0000, 16'h0001, 4'd9},
      {OP_RD,  1'b0, 16'h0000, 16'h0003, 4'd8},
      {OP_RXC, 1'b0, 16'h0000, 16'h0000, 4'd9},
      {OP_PUSH,1'b0, 16'h0010, 16'h0000, 4'd7},
      {OP_PUSH,1'b0, 16'h0020, 16'h0000, 4'd7},
      {OP_PUSH,1'b0, 16'h0030, 16'h0000, 4'd7},
      {OP_PUSH,1'b0, 16'h0040, 16'h0000, 4'd7},
      {OP_RD,  1'b0, 16'h0000, 16'h2010, 4'd8},
      {OP_RD,  1'b1, 16'h0000, 16'h3040, 4'd8},
      {OP_RXC, 1'b0, 16'h0000, 16'h0000, 4'd9}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        big_endian = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic        tx_pop = 1'b0, rx_push = 1'b0;
   logic [15:0] wr_data = '0;
   logic [7:0]  rx_byte = '0;
   logic [15:0] rd_data;
   logic [7:0]  tx_byte;
   logic [2:0]  tx_count, rx_count;
   logic        tx_valid, tx_ready, tx_underflow, rx_ready, rx_overrun, rx_single;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pkb_buffer u_pkb_buffer (
      .clk (clk), .rst_n (rst_n), .big_endian (big_endian),
      .wr_en (wr_en), .wr_data (wr_data), .rd_en (rd_en), .rd_data (rd_data),
      .tx_pop (tx_pop), .tx_valid (tx_valid), .tx_byte (tx_byte),
      .rx_push (rx_push), .rx_byte (rx_byte),
      .tx_count (tx_count), .rx_count (rx_count),
      .tx_ready (tx_ready), .tx_underflow (tx_underflow),
      .rx_ready (rx_ready), .rx_overrun (rx_overrun), .rx_single (rx_single)
   );

   function automatic string rname(input logic [3:0] n);
      case (n)
         4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
         4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
         4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic do_write(input logic be, input logic [15:0] d);
      @(negedge clk); big_endian = be; wr_data = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_pop(output logic [7:0] b);
      @(negedge clk); tx_pop = 1'b1; #1 b = tx_byte;
      @(negedge clk); tx_pop = 1'b0;
   endtask

   task automatic do_push(input logic [7:0] b);
      @(negedge clk); rx_byte = b; rx_push = 1'b1;
      @(negedge clk); rx_push = 1'b0;
   endtask

   task automatic do_read(input logic be, output logic [15:0] w);
      @(negedge clk); big_endian = be; rd_en = 1'b1; #1 w = rd_data;
      @(negedge clk); rd_en = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] w;
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk("R1", "tx_count", 16'(tx_count), 16'h0);
      chk("R1", "rx_count", 16'(rx_count), 16'h0);
      chk("R1", "flags", {11'h0, tx_ready, tx_underflow, rx_ready, rx_overrun, rx_single}, 16'h0);
      chk("R1", "tx_valid/tx_byte", {7'h0, tx_valid, tx_byte}, 16'h0);
      chk("R1", "rd_data", rd_data, 16'h0);

      for (int k = 0; k < NV; k++) begin
         logic [39:0] v;
         v = VECS[k];
         case (v[39:37])
            OP_WR:   do_write(v[36], v[35:20]);
            OP_POP:  begin do_pop(b); chk(rname(v[3:0]), "tx_byte", 16'(b), v[19:4]); end
            OP_PUSH: do_push(v[27:20]);
            OP_RD:   begin do_read(v[36], w); chk(rname(v[3:0]), "rd_data", w, v[19:4]); end
            OP_TXC:  begin @(negedge clk); chk(rname(v[3:0]), "tx_count", 16'(tx_count), v[19:4]); end
            default: begin @(negedge clk); chk(rname(v[3:0]), "rx_count", 16'(rx_count), v[19:4]); end
         endcase
      end

      // transmit flags
      do_reset();
      do_pop(b);
      chk("R5", "empty pop byte", 16'(b), 16'h0);
      chk("R5", "underflow set", 16'(tx_underflow), 16'h1);
      chk("R6", "ready after pop", 16'(tx_ready), 16'h1);
      do_write(1'b1, 16'h1234);
      chk("R5", "underflow cleared by write", 16'(tx_underflow), 16'h0);
      chk("R6", "ready kept at 2 bytes", 16'(tx_ready), 16'h1);
      chk("R4", "tx_valid with data", 16'(tx_valid), 16'h1);
      do_write(1'b1, 16'h5678);
      chk("R6", "ready cleared above 2 bytes", 16'(tx_ready), 16'h0);
      do_pop(b);
      chk("R6", "ready after pop", 16'(tx_ready), 16'h1);
      do_pop(b); do_pop(b); do_pop(b);
      chk("R4", "last byte", 16'(b), 16'h0078);
      chk("R4", "tx_valid when empty", 16'(tx_valid), 16'h0);

      // receive flags
      do_reset();
      do_push(8'hE1);
      chk("R7", "rx_ready after push", 16'(rx_ready), 16'h1);
      do_push(8'hE2); do_push(8'hE3); do_push(8'hE4);
      chk("R7", "no overrun at 4", 16'(rx_overrun), 16'h0);
      do_push(8'hEE);
      chk("R7", "overrun when full", 16'(rx_overrun), 16'h1);
      chk("R7", "count held at full", 16'(rx_count), 16'h4);
      do_read(1'b0, w);
      chk("R7", "data kept after overrun", w, 16'hE2E1);
      chk("R10", "read clears overrun", 16'(rx_overrun), 16'h0);
      chk("R10", "ready while bytes remain", 16'(rx_ready), 16'h1);
      do_read(1'b1, w);
      chk("R8", "second pair big order", w, 16'hE3E4);
      chk("R10", "ready cleared when empty", 16'(rx_ready), 16'h0);
      chk("R9", "no single flag after pairs", 16'(rx_single), 16'h0);
      do_read(1'b0, w);
      chk("R9", "empty read count", 16'(rx_count), 16'h0);
      chk("R9", "empty read leaves single", 16'(rx_single), 16'h0);
      do_push(8'h5A);
      do_read(1'b1, w);
      chk("R8", "single byte big order", w, 16'h5A00);
      chk("R9", "single flag set", 16'(rx_single), 16'h1);
      chk("R9", "single read empties", 16'(rx_count), 16'h0);
      do_push(8'h61); do_push(8'h62);
      do_read(1'b0, w);
      chk("R9", "pair read clears single", 16'(rx_single), 16'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule